// File: doc/BRIEF.md
# Sparse Matrix-Vector Pipeline Unit

This block multiplies a sparse matrix K by a vector p and, in the same pass, forms the scalar pᵀKp. The matrix sits in a local memory as a list of 32-bit words, one per stored non-zero. Each word carries its column index, its signed fixed-point value and two marker bits. One marker closes the current row. The other closes the whole matrix. Rows are taken in order from row 0. A row with no non-zeros is stored as a zero-valued word with the row marker set.

A pulse on `start` while the unit is idle clears the results. The unit then reads words from addresses 0, 1, 2, … at one per cycle. Each word passes through a fetch stage, a decode stage and an execute stage. Decode splits the word and picks the matching element of p. Execute multiply-accumulates the row sum. When a row closes, execute writes the rounded row sum into the Kp output. It also adds p[row]·Kp[row] into the pᵀKp accumulator.

The run ends on the matrix marker. Its length depends only on the number of stored words, not on the matrix dimensions. Values use 21-bit two's complement with 10 fractional bits. Sums are held in 48 bits and are rounded on the way out.

Top module: `spmv_pipe`

## Requirements
- R1: A word is decoded as follows. Bit 31 is the end-of-matrix marker. Bit 30 is the end-of-row marker. Bits 29:21 hold the column index. Bits 20:0 hold a signed value with 10 fractional bits. The vector element selected is p[column], and a column index ≥ N selects zero.
- R2: A `start` seen while idle makes `busy` high on the next cycle and drives `mem_en` with `mem_addr` = 0. The address then rises by one each cycle while `mem_en` stays high. `mem_en` is never high while `busy` is low.
- R3: When a word with either marker set is executed, the unit writes the rounded sum of value×p[column] over that row's words into Kp[row]. The row counter starts at 0 and advances by one per closed row. Kp[r] sits at bits r·21 … r·21+20 of `kp_vec`.
- R4: `pkp` equals the rounded value of the sum, over closed rows, of p[row]×Kp[row]. Here Kp[row] is the already rounded 21-bit row result.
- R5: Rounding adds 2⁹ to the 48-bit sum, which carries 20 fractional bits. It then shifts right arithmetically by 10 and keeps the low 21 bits. For example, a product equal to half an output LSB rounds up, while minus half an LSB rounds to 0.
- R6: A zero-valued word with the end-of-row marker set closes a row with Kp[row] = 0, and the next word belongs to the following row.
- R7: The end-of-matrix word counts as a value and also closes its row. After it, `done` rises and `busy` falls in the same cycle. For a matrix of M words, that cycle comes exactly M+2 cycles after the edge that accepted `start`.
- R8: A `start` pulse while `busy` is high is ignored. Results and run length are unchanged.
- R9: An accepted `start` clears `done`, `pkp` and every Kp element. Rows a run does not reach read zero afterwards.
- R10: After reset, `busy`, `done`, `mem_en`, `pkp` and all of `kp_vec` are zero.
- R11: Once `done` is high, `done`, `kp_vec` and `pkp` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| mem_en | output | 1 | Matrix memory read enable |
| mem_addr | output | ADDR_W | Matrix memory read address |
| mem_rdata | input | 32 | Word returned one cycle after a read |
| p_vec | input | N·21 | Multiplying vector, element i at bits i·21+20:i·21 |
| kp_vec | output | N·21 | Kp result vector, same packing as p_vec |
| pkp | output | 21 | pᵀKp result |
| busy | output | 1 | A run is in the pipeline |
| done | output | 1 | Last run finished; results valid |

## Verification
The assertions assume three things about the inputs. The memory answers a read exactly one cycle later. A run's word list ends with an end-of-matrix word before the row count exceeds N. p_vec stays constant during a run. The bench memory model is a one-cycle registered read. Every matrix it loads closes no more than N rows and ends with the matrix marker. The vector is changed only while the unit is idle. Values are kept small enough that no row or pᵀKp sum leaves the 21-bit result range, so the bench's unbounded integer model and the design agree.

// File: rtl/spmv_pipe.sv
module spmv_pipe #(
  parameter int N      = 16,
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                mem_en,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [31:0]         mem_rdata,
  input  logic [N*21-1:0]     p_vec,
  output logic [N*21-1:0]     kp_vec,
  output logic [20:0]         pkp,
  output logic                busy,
  output logic                done
);
  localparam int VW = 21;
  localparam int CW = 9;
  localparam int FB = 10;
  localparam int AW = 48;
  localparam int PW = 2 * VW;
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  function automatic logic signed [VW-1:0] rnd(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] t;
    t = a + (AW'(1) <<< (FB - 1));
    return t[FB +: VW];
  endfunction

  logic                 running, f_valid;
  logic [ADDR_W-1:0]    pc;
  logic                 d_valid, d_eor, d_eom;
  logic signed [VW-1:0] d_val, d_pel, pel, prow, row_res;
  logic signed [PW-1:0] prod, pprod;
  logic signed [AW-1:0] row_acc, pkp_acc, sum;
  logic [RW-1:0]        row;

  assign busy     = running | f_valid | d_valid;
  assign mem_en   = running;
  assign mem_addr = pc;

  wire start_ok = start && !busy;
  wire f_eom    = f_valid && mem_rdata[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
      f_valid <= 1'b0;
    end else begin
      f_valid <= running && !f_eom;
      if (start_ok) begin
        running <= 1'b1;
        pc      <= '0;
      end else if (running) begin
        pc <= pc + 1'b1;
        if (f_eom) running <= 1'b0;
      end
    end
  end

  always_comb begin
    pel = '0;
    for (int i = 0; i < N; i++)
      if (mem_rdata[29:21] == CW'(i)) pel = p_vec[i*VW +: VW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_eor   <= 1'b0;
      d_eom   <= 1'b0;
      d_val   <= '0;
      d_pel   <= '0;
    end else begin
      d_valid <= f_valid;
      d_eor   <= mem_rdata[30] | mem_rdata[31];
      d_eom   <= mem_rdata[31];
      d_val   <= mem_rdata[20:0];
      d_pel   <= pel;
    end
  end

  always_comb begin
    prow = '0;
    for (int i = 0; i < N; i++)
      if (row == RW'(i)) prow = p_vec[i*VW +: VW];
  end

  assign prod    = d_val * d_pel;
  assign sum     = row_acc + {{(AW-PW){prod[PW-1]}}, prod};
  assign row_res = rnd(sum);
  assign pprod   = prow * row_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_acc <= '0;
      pkp_acc <= '0;
      row     <= '0;
      kp_vec  <= '0;
      done    <= 1'b0;
    end else if (start_ok) begin
      row_acc <= '0;
      pkp_acc <= '0;
      row     <= '0;
      kp_vec  <= '0;
      done    <= 1'b0;
    end else if (d_valid) begin
      if (d_eor) begin
        kp_vec[row*VW +: VW] <= row_res;
        pkp_acc <= pkp_acc + {{(AW-PW){pprod[PW-1]}}, pprod};
        row_acc <= '0;
        row     <= row + 1'b1;
        done    <= d_eom;
      end else begin
        row_acc <= sum;
      end
    end
  end

  assign pkp = rnd(pkp_acc);
endmodule

// File: rtl/spmv_pipe_checker.sv
module spmv_pipe_checker #(
  parameter int N      = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [N*21-1:0]   kp_vec,
  input logic [20:0]       pkp,
  input logic              busy,
  input logic              done
);
  assert_idle_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_en && mem_addr == '0));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!done && pkp == '0 && kp_vec == '0));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(kp_vec) && $stable(pkp)));
endmodule

bind spmv_pipe spmv_pipe_checker #(.N(N), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_en(mem_en), .mem_addr(mem_addr),
  .kp_vec(kp_vec), .pkp(pkp), .busy(busy), .done(done)
);

// File: tb/spmv_pipe_test.sv
module spmv_pipe_test;
  localparam int N = 16;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic mem_en;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [N*21-1:0] p_vec, kp_vec;
  logic [20:0] pkp;
  logic busy, done;

  logic [31:0] mem [0:63];
  logic signed [20:0] pv [N];
  logic signed [20:0] kpe [N];
  logic signed [20:0] pkpe;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) p_vec[i*21 +: 21] = pv[i];

  always @(posedge clk) if (mem_en) mem_rdata <= (mem_addr < 64) ? mem[mem_addr[5:0]] : 32'h0;

  spmv_pipe #(.N(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .p_vec(p_vec), .kp_vec(kp_vec), .pkp(pkp),
    .busy(busy), .done(done));

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input bit eom, input bit eor, input int col, input int val);
    logic [8:0] c = col[8:0];
    logic [20:0] v = val[20:0];
    return {eom, eor, c, v};
  endfunction

  function automatic logic signed [20:0] rnd(input longint a);
    longint t;
    t = (a + 512) >>> 10;
    return t[20:0];
  endfunction

  function automatic logic signed [20:0] kp_at(input int i);
    return kp_vec[i*21 +: 21];
  endfunction

  task automatic model(input int m);
    longint acc = 0, pacc = 0;
    int row = 0;
    for (int i = 0; i < N; i++) kpe[i] = '0;
    for (int k = 0; k < m; k++) begin
      logic [31:0] e = mem[k];
      logic signed [20:0] v = e[20:0];
      int col = int'(e[29:21]);
      longint lv = v;
      longint lp = (col < N) ? longint'(pv[col]) : 0;
      acc += lv * lp;
      if (e[30] || e[31]) begin
        kpe[row] = rnd(acc);
        pacc += longint'(pv[row]) * longint'(kpe[row]);
        row++;
        acc = 0;
      end
      if (e[31]) break;
    end
    pkpe = rnd(pacc);
  endtask

  task automatic run(input int m, input int inject, input string req);
    int cnt = 0;
    model(m);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && cnt < 1000) begin
      start = (cnt == inject);
      @(negedge clk);
      cnt++;
    end
    start = 0;
    chk({req, " R7 cycles"}, cnt, m + 2);
    chk({req, " R7 busy low"}, busy, 0);
    for (int i = 0; i < N; i++) chk({req, " R3 kp"}, kp_at(i), kpe[i]);
    chk({req, " R4 pkp"}, $signed(pkp), pkpe);
  endtask

  task automatic t_reset;
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 mem_en", mem_en, 0);
    chk("R10 pkp", pkp, 0);
    chk("R10 kp", kp_vec == '0, 1);
  endtask

  task automatic t_diag;
    for (int i = 0; i < N; i++) pv[i] = 21'(i * 256 - 1000);
    mem[0] = ent(0, 1, 0, 1024);
    mem[1] = ent(0, 1, 1, 2048);
    mem[2] = ent(0, 1, 2, -1024);
    mem[3] = ent(1, 0, 3, 512);
    run(4, -1, "diag R1");
  endtask

  task automatic t_dense;
    for (int i = 0; i < N; i++) pv[i] = 21'(300 - i * 77);
    mem[0] = ent(0, 0, 0, 1500);
    mem[1] = ent(0, 0, 5, -700);
    mem[2] = ent(0, 1, 15, 333);
    mem[3] = ent(0, 0, 2, -2048);
    mem[4] = ent(0, 1, 20, 999);
    mem[5] = ent(0, 0, 7, 1023);
    mem[6] = ent(1, 1, 9, -1);
    run(7, -1, "dense R1 R5");
  endtask

  task automatic t_empty;
    for (int i = 0; i < N; i++) pv[i] = 21'(1024 + i * 10);
    mem[0] = ent(0, 1, 1, 1024);
    mem[1] = ent(0, 1, 0, 0);
    mem[2] = ent(1, 0, 2, 3072);
    run(3, -1, "empty R6");
    chk("R6 placeholder row", kp_at(1), 0);
    chk("R6 next row", kp_at(2), 3 * (1024 + 20));
  endtask

  task automatic t_round;
    for (int i = 0; i < N; i++) pv[i] = 21'(512);
    mem[0] = ent(0, 1, 0, 1);
    mem[1] = ent(0, 1, 0, -1);
    mem[2] = ent(1, 0, 0, -3);
    run(3, -1, "round");
    chk("R5 half up", kp_at(0), 1);
    chk("R5 minus half", kp_at(1), 0);
    chk("R5 minus 1.5", kp_at(2), -1);
  endtask

  task automatic t_single;
    for (int i = 0; i < N; i++) pv[i] = 21'(2048);
    mem[0] = ent(1, 0, 4, 1536);
    run(1, -1, "single R7");
    chk("R7 eom closes row", kp_at(0), 3072);
  endtask

  task automatic t_busy_start;
    for (int i = 0; i < N; i++) pv[i] = 21'(i * 100 + 50);
    for (int k = 0; k < 6; k++) mem[k] = ent(k == 5, k % 2, k, 200 * k - 300);
    run(6, 2, "busy start R8");
  endtask

  task automatic t_restart;
    for (int i = 0; i < N; i++) pv[i] = 21'(700);
    for (int k = 0; k < 4; k++) mem[k] = ent(k == 3, 1, k, 1024);
    run(4, -1, "prior");
    mem[0] = ent(1, 0, 0, 2048);
    run(1, -1, "restart R9");
    chk("R9 row1 cleared", kp_at(1), 0);
    chk("R9 row3 cleared", kp_at(3), 0);
    begin
      logic [N*21-1:0] kv = kp_vec;
      logic [20:0] pk = pkp;
      repeat (5) @(negedge clk);
      chk("R11 done held", done, 1);
      chk("R11 kp held", kp_vec == kv, 1);
      chk("R11 pkp held", pkp == pk, 1);
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    for (int i = 0; i < N; i++) pv[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_diag;
    t_dense;
    t_empty;
    t_round;
    t_single;
    t_busy_start;
    t_restart;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #1_000_000;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule